// File: doc/BRIEF.md
# Guest Event Exit Filter

This block runs beside a small processor pipeline that executes guest code under a monitor. The pipeline presents each guest event on a valid/ready port. The event carries its kind, an address field (a control register number, port number or vector) and write data. For each event the block decides whether control must pass to the monitor. If it must, the block raises an exit request with a reason code and holds it until the monitor acknowledges it. If not, the block completes the event in place and returns a one-cycle response with any read data.

Exits are filtered finely rather than taken on every privileged operation. Control registers 0 and 4 each have a guest/host mask and a read shadow. Exceptions are filtered through a 32-bit per-vector bitmap and I/O ports through a per-port bitmap. Timestamp reads have an offset added. Page invalidates, external interrupts and an interrupt-window condition each have an enable bit. The monitor programs all of these through a simple write port.

The event port follows valid/ready rules. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low while an exit is pending, and also in any cycle where an interrupt-window exit is being raised. The source must then hold its event until it is taken. The response output has no back-pressure: `resp_valid` is a one-cycle pulse that the consumer must always accept.

Top module: `vx_exit_eval`

## Requirements
- R1: Event kind 0 (control register read) with register number 0 or 4 in `ev_addr[3:0]` completes without an exit. Its response data is (shadow AND mask) OR (current value AND NOT mask) for that register.
- R2: Event kind 1 (control register write) to register 0 or 4 raises exit reason 1 when the write data differs from the current value in any bit set in that register's mask, and the current value is then left unchanged. Otherwise the write completes and becomes the current value.
- R3: Event kind 1 to register 3 always raises exit reason 2.
- R4: Event kind 4 (exception) raises exit reason 4 when bit `ev_addr[4:0]` of the exception bitmap is set; otherwise it completes.
- R5: Event kind 3 (I/O access) raises exit reason 3 when the I/O bitmap bit indexed by `ev_addr` is set; otherwise it completes.
- R6: Event kind 2 (timestamp read) never exits. It completes with `tsc_in` plus the 64-bit offset, modulo 2^64.
- R7: Event kind 5 (page invalidate) raises exit reason 5 when control bit 0 is set; otherwise it completes.
- R8: Event kind 6 (capability query) always raises exit reason 6.
- R9: Event kind 7 (external interrupt) raises exit reason 7 when control bit 1 is set, whatever `guest_ie` is; otherwise it completes.
- R10: When control bit 2 is set and `guest_ie` is 1 with no exit pending, exit reason 8 is raised at the next edge. In that cycle `ev_ready` is low, so a simultaneous event is not taken.
- R11: `exit_req` and `exit_reason` stay constant until an edge with `exit_ack` high clears them. `ev_ready` is low while `exit_req` is high, and events offered then have no effect.
- R12: Each event that is taken produces exactly one result at the following edge: either a `resp_valid` pulse or a rising `exit_req`.
- R13: After reset, `exit_req` and `resp_valid` are 0, `ev_ready` is 1 and all configuration is zero. The configuration write addresses are:
  - 0: mask for register 0
  - 1: shadow for register 0
  - 2: mask for register 4
  - 3: shadow for register 4
  - 4: exception bitmap
  - 5: low half of the timestamp offset
  - 6: high half of the timestamp offset
  - 7: control bits
  - 8: current value of register 0
  - 9: current value of register 4
  - 32 + w: I/O bitmap word w, covering ports 32w to 32w+31

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| ev_valid | input | 1 | Guest event offered |
| ev_ready | output | 1 | Guest event can be taken |
| ev_kind | input | 3 | Event kind code |
| ev_addr | input | 8 | Register number, port or vector |
| ev_wdata | input | 32 | Write data for register writes |
| guest_ie | input | 1 | Guest interrupt-enable flag |
| tsc_in | input | 64 | Physical timestamp counter |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_data | output | 64 | Completion read data |
| exit_req | output | 1 | Exit to monitor pending |
| exit_reason | output | 4 | Exit reason code |
| exit_ack | input | 1 | Monitor acknowledges the exit |

## Verification
The bench targets masked versus unmasked register writes: a design that compared whole words would exit on harmless writes, and one that skipped the mask would let the guest change protected bits. It probes bitmap bits beside a set bit, so an off-by-one index shows up as a wrong exit or a missing one. It also checks a timestamp sum that carries across the 32-bit boundary, which a truncated adder would get wrong. Finally, it offers an event in the same cycle as an interrupt-window exit and during a pending exit. A design that accepted the event would emit a stray response or replace the reason code.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [2:0] {
    EV_CRRD   = 3'd0,
    EV_CRWR   = 3'd1,
    EV_TSC    = 3'd2,
    EV_IO     = 3'd3,
    EV_EXC    = 3'd4,
    EV_INVL   = 3'd5,
    EV_CAP    = 3'd6,
    EV_EXTINT = 3'd7
  } ev_kind_e;

  typedef enum logic [3:0] {
    RS_NONE   = 4'd0,
    RS_CRWR   = 4'd1,
    RS_CR3    = 4'd2,
    RS_IO     = 4'd3,
    RS_EXC    = 4'd4,
    RS_INVL   = 4'd5,
    RS_CAP    = 4'd6,
    RS_EXTINT = 4'd7,
    RS_INTWIN = 4'd8
  } rsn_e;

  typedef struct packed {
    logic intwin;
    logic extint;
    logic invl;
  } ctl_t;
endpackage

// File: rtl/vx_cfg_regs.sv
module vx_cfg_regs
  import vx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PORTS  = 256,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              gst_we,
  input  logic              gst_sel,
  input  logic [DW-1:0]     gst_wdata,
  output logic [DW-1:0]     cr0_mask,
  output logic [DW-1:0]     cr0_shad,
  output logic [DW-1:0]     cr4_mask,
  output logic [DW-1:0]     cr4_shad,
  output logic [DW-1:0]     cr0_val,
  output logic [DW-1:0]     cr4_val,
  output logic [DW-1:0]     exc_map,
  output logic [2*DW-1:0]   tsc_off,
  output ctl_t              ctl,
  output logic [PORTS-1:0]  io_map
);
  localparam int IO_WORDS = PORTS / DW;
  localparam int IO_BASE  = 32;
  localparam logic [CFG_AW-1:0] A_CR0M = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] A_CR0S = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] A_CR4M = CFG_AW'(2);
  localparam logic [CFG_AW-1:0] A_CR4S = CFG_AW'(3);
  localparam logic [CFG_AW-1:0] A_EXC  = CFG_AW'(4);
  localparam logic [CFG_AW-1:0] A_OFFL = CFG_AW'(5);
  localparam logic [CFG_AW-1:0] A_OFFH = CFG_AW'(6);
  localparam logic [CFG_AW-1:0] A_CTL  = CFG_AW'(7);
  localparam logic [CFG_AW-1:0] A_CR0V = CFG_AW'(8);
  localparam logic [CFG_AW-1:0] A_CR4V = CFG_AW'(9);

  logic [DW-1:0] io_words [IO_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_mask <= '0;
      cr0_shad <= '0;
      cr4_mask <= '0;
      cr4_shad <= '0;
      cr0_val  <= '0;
      cr4_val  <= '0;
      exc_map  <= '0;
      tsc_off  <= '0;
      ctl      <= '0;
      for (int w = 0; w < IO_WORDS; w++) io_words[w] <= '0;
    end else begin
      // guest in-place update first, so a monitor write in the same cycle wins
      if (gst_we) begin
        if (gst_sel) cr4_val <= gst_wdata;
        else         cr0_val <= gst_wdata;
      end
      if (cfg_we) begin
        case (cfg_addr)
          A_CR0M: cr0_mask <= cfg_wdata;
          A_CR0S: cr0_shad <= cfg_wdata;
          A_CR4M: cr4_mask <= cfg_wdata;
          A_CR4S: cr4_shad <= cfg_wdata;
          A_EXC:  exc_map  <= cfg_wdata;
          A_OFFL: tsc_off[DW-1:0]    <= cfg_wdata;
          A_OFFH: tsc_off[2*DW-1:DW] <= cfg_wdata;
          A_CTL:  ctl      <= ctl_t'(cfg_wdata[2:0]);
          A_CR0V: cr0_val  <= cfg_wdata;
          A_CR4V: cr4_val  <= cfg_wdata;
          default: ;
        endcase
        for (int w = 0; w < IO_WORDS; w++)
          if (cfg_addr == CFG_AW'(IO_BASE + w)) io_words[w] <= cfg_wdata;
      end
    end
  end

  for (genvar w = 0; w < IO_WORDS; w++) begin : g_io
    assign io_map[w*DW +: DW] = io_words[w];
  end
endmodule

// File: rtl/vx_exit_decide.sv
module vx_exit_decide
  import vx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int PORTS = 256
) (
  input  logic [2:0]       kind,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    cr0_mask,
  input  logic [DW-1:0]    cr0_shad,
  input  logic [DW-1:0]    cr4_mask,
  input  logic [DW-1:0]    cr4_shad,
  input  logic [DW-1:0]    cr0_val,
  input  logic [DW-1:0]    cr4_val,
  input  logic [DW-1:0]    exc_map,
  input  logic [2*DW-1:0]  tsc_off,
  input  ctl_t             ctl,
  input  logic [PORTS-1:0] io_map,
  input  logic [2*DW-1:0]  tsc_in,
  output logic             do_exit,
  output rsn_e             reason,
  output logic [2*DW-1:0]  rdata,
  output logic             gst_we,
  output logic             gst_sel
);
  localparam int PW = $clog2(PORTS);
  localparam int VW = $clog2(DW);

  logic [3:0] crn;
  assign crn = addr[3:0];

  always_comb begin
    do_exit = 1'b0;
    reason  = RS_NONE;
    rdata   = '0;
    gst_we  = 1'b0;
    gst_sel = 1'b0;
    case (ev_kind_e'(kind))
      EV_CRRD: begin
        if (crn == 4'd0)
          rdata = {{DW{1'b0}}, (cr0_shad & cr0_mask) | (cr0_val & ~cr0_mask)};
        else if (crn == 4'd4)
          rdata = {{DW{1'b0}}, (cr4_shad & cr4_mask) | (cr4_val & ~cr4_mask)};
      end
      EV_CRWR: begin
        if (crn == 4'd3) begin
          do_exit = 1'b1;
          reason  = RS_CR3;
        end else if (crn == 4'd0) begin
          if (|((wdata ^ cr0_val) & cr0_mask)) begin
            do_exit = 1'b1;
            reason  = RS_CRWR;
          end else gst_we = 1'b1;
        end else if (crn == 4'd4) begin
          gst_sel = 1'b1;
          if (|((wdata ^ cr4_val) & cr4_mask)) begin
            do_exit = 1'b1;
            reason  = RS_CRWR;
          end else gst_we = 1'b1;
        end
      end
      EV_TSC: rdata = tsc_in + tsc_off;
      EV_IO: if (io_map[addr[PW-1:0]]) begin
        do_exit = 1'b1;
        reason  = RS_IO;
      end
      EV_EXC: if (exc_map[addr[VW-1:0]]) begin
        do_exit = 1'b1;
        reason  = RS_EXC;
      end
      EV_INVL: if (ctl.invl) begin
        do_exit = 1'b1;
        reason  = RS_INVL;
      end
      EV_CAP: begin
        do_exit = 1'b1;
        reason  = RS_CAP;
      end
      EV_EXTINT: if (ctl.extint) begin
        do_exit = 1'b1;
        reason  = RS_EXTINT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vx_exit_eval.sv
module vx_exit_eval
  import vx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int PORTS  = 256,
  parameter int CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [2:0]        ev_kind,
  input  logic [AW-1:0]     ev_addr,
  input  logic [DW-1:0]     ev_wdata,
  input  logic              guest_ie,
  input  logic [2*DW-1:0]   tsc_in,
  output logic              resp_valid,
  output logic [2*DW-1:0]   resp_data,
  output logic              exit_req,
  output logic [3:0]        exit_reason,
  input  logic              exit_ack
);
  logic [DW-1:0]    cr0_mask, cr0_shad, cr4_mask, cr4_shad, cr0_val, cr4_val, exc_map;
  logic [2*DW-1:0]  tsc_off, dec_rdata;
  ctl_t             ctl;
  logic [PORTS-1:0] io_map;
  logic             dec_exit, dec_gst_we, gst_sel, ev_fire, intwin_hit;
  rsn_e             dec_reason;

  vx_cfg_regs #(.DW(DW), .PORTS(PORTS), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gst_we(dec_gst_we && ev_fire), .gst_sel(gst_sel),
    .gst_wdata(ev_wdata), .cr0_mask(cr0_mask), .cr0_shad(cr0_shad),
    .cr4_mask(cr4_mask), .cr4_shad(cr4_shad), .cr0_val(cr0_val),
    .cr4_val(cr4_val), .exc_map(exc_map), .tsc_off(tsc_off), .ctl(ctl),
    .io_map(io_map)
  );

  vx_exit_decide #(.DW(DW), .AW(AW), .PORTS(PORTS)) u_dec (
    .kind(ev_kind), .addr(ev_addr), .wdata(ev_wdata),
    .cr0_mask(cr0_mask), .cr0_shad(cr0_shad), .cr4_mask(cr4_mask),
    .cr4_shad(cr4_shad), .cr0_val(cr0_val), .cr4_val(cr4_val),
    .exc_map(exc_map), .tsc_off(tsc_off), .ctl(ctl), .io_map(io_map),
    .tsc_in(tsc_in), .do_exit(dec_exit), .reason(dec_reason),
    .rdata(dec_rdata), .gst_we(dec_gst_we), .gst_sel(gst_sel)
  );

  // interrupt window outranks any event offered in the same cycle
  assign intwin_hit = ctl.intwin && guest_ie && !exit_req;
  assign ev_ready   = !exit_req && !intwin_hit;
  assign ev_fire    = ev_valid && ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_req    <= 1'b0;
      exit_reason <= RS_NONE;
      resp_valid  <= 1'b0;
      resp_data   <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (exit_req) begin
        if (exit_ack) begin
          exit_req    <= 1'b0;
          exit_reason <= RS_NONE;
        end
      end else if (intwin_hit) begin
        exit_req    <= 1'b1;
        exit_reason <= RS_INTWIN;
      end else if (ev_fire) begin
        if (dec_exit) begin
          exit_req    <= 1'b1;
          exit_reason <= dec_reason;
        end else begin
          resp_valid <= 1'b1;
          resp_data  <= dec_rdata;
        end
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && !exit_ack |=> exit_req && $stable(exit_reason));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> !ev_ready);
  p_cr3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == EV_CRWR && ev_addr[3:0] == 4'd3
    |=> exit_req && exit_reason == RS_CR3);
  p_tsc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == EV_TSC |=> resp_valid && !exit_req);
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == EV_CAP |=> exit_req && exit_reason == RS_CAP);
  p_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> resp_valid != exit_req);
  p_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.intwin && guest_ie && !exit_req |=> exit_req && exit_reason == RS_INTWIN);
endmodule

// File: tb/sim_vx_exit_eval.sv
`timescale 1ns/1ps
module sim_vx_exit_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_kind = '0;
  logic [7:0]  ev_addr = '0;
  logic [31:0] ev_wdata = '0;
  logic        guest_ie = 1'b0;
  logic [63:0] tsc_in = '0;
  logic        resp_valid;
  logic [63:0] resp_data;
  logic        exit_req;
  logic [3:0]  exit_reason;
  logic        exit_ack = 1'b0;

  int total = 0;
  int bad = 0;
  logic        g_exit, g_resp;
  logic [3:0]  g_rsn;
  logic [63:0] g_data;

  always #2 clk = ~clk;

  vx_exit_eval u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_wdata(ev_wdata),
    .guest_ie(guest_ie), .tsc_in(tsc_in), .resp_valid(resp_valid),
    .resp_data(resp_data), .exit_req(exit_req), .exit_reason(exit_reason),
    .exit_ack(exit_ack)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    exit_ack = 1'b1;
    @(posedge clk); #1;
    exit_ack = 1'b0;
  endtask

  task automatic run_ev(input logic [2:0] k, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_wdata = d;
    @(posedge clk); #1;
    ev_valid = 1'b0;
    g_exit = exit_req; g_rsn = exit_reason; g_resp = resp_valid; g_data = resp_data;
    if (g_exit) ack();
  endtask

  task automatic t_reset();
    chk("R13 exit_req", {63'd0, exit_req}, 64'd0);
    chk("R13 resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R13 ev_ready", {63'd0, ev_ready}, 64'd1);
    run_ev(3'd0, 8'd0, 32'd0);
    chk("R13 cr0 zero", g_data, 64'd0);
  endtask

  task automatic t_cr();
    cfg_wr(6'd0, 32'h0000_00F0);
    cfg_wr(6'd1, 32'h0000_00A0);
    cfg_wr(6'd8, 32'h1234_5678);
    run_ev(3'd0, 8'd0, 32'd0);
    chk("R1 read resp", {63'd0, g_resp}, 64'd1);
    chk("R1 read noexit", {63'd0, g_exit}, 64'd0);
    chk("R1 read data", g_data, 64'h1234_56A8);
    run_ev(3'd1, 8'd0, 32'h1234_5F73);
    chk("R2 unmasked write completes", {63'd0, g_resp}, 64'd1);
    chk("R12 one result", {63'd0, g_exit}, 64'd0);
    run_ev(3'd0, 8'd0, 32'd0);
    chk("R2 write applied", g_data, 64'h1234_5FA3);
    run_ev(3'd1, 8'd0, 32'h1234_5F03);
    chk("R2 masked write exits", {63'd0, g_exit}, 64'd1);
    chk("R2 reason", {60'd0, g_rsn}, 64'd1);
    chk("R12 no resp on exit", {63'd0, g_resp}, 64'd0);
    run_ev(3'd0, 8'd0, 32'd0);
    chk("R2 value unchanged", g_data, 64'h1234_5FA3);
    cfg_wr(6'd2, 32'h0000_0001);
    cfg_wr(6'd3, 32'h0000_0001);
    run_ev(3'd0, 8'd4, 32'd0);
    chk("R1 cr4 read", g_data, 64'd1);
    run_ev(3'd1, 8'd3, 32'd0);
    chk("R3 cr3 exit", {63'd0, g_exit}, 64'd1);
    chk("R3 reason", {60'd0, g_rsn}, 64'd2);
  endtask

  task automatic t_bitmaps();
    cfg_wr(6'd4, 32'h0000_4000);
    run_ev(3'd4, 8'd14, 32'd0);
    chk("R4 vector 14 exits", {63'd0, g_exit}, 64'd1);
    chk("R4 reason", {60'd0, g_rsn}, 64'd4);
    run_ev(3'd4, 8'd13, 32'd0);
    chk("R4 vector 13 completes", {63'd0, g_resp}, 64'd1);
    cfg_wr(6'd34, 32'h0000_0020);
    run_ev(3'd3, 8'd69, 32'd0);
    chk("R5 port 69 exits", {63'd0, g_exit}, 64'd1);
    chk("R5 reason", {60'd0, g_rsn}, 64'd3);
    run_ev(3'd3, 8'd70, 32'd0);
    chk("R5 port 70 completes", {63'd0, g_resp}, 64'd1);
    run_ev(3'd3, 8'd5, 32'd0);
    chk("R5 port 5 completes", {63'd0, g_resp}, 64'd1);
  endtask

  task automatic t_tsc();
    tsc_in = 64'hFFFF_FFFF_0000_0010;
    cfg_wr(6'd5, 32'hFFFF_FFF5);
    cfg_wr(6'd6, 32'h0000_0001);
    run_ev(3'd2, 8'd0, 32'd0);
    chk("R6 noexit", {63'd0, g_exit}, 64'd0);
    chk("R6 sum", g_data, 64'hFFFF_FFFF_0000_0010 + 64'h0000_0001_FFFF_FFF5);
  endtask

  task automatic t_ctl();
    run_ev(3'd5, 8'd0, 32'd0);
    chk("R7 invalidate off completes", {63'd0, g_resp}, 64'd1);
    run_ev(3'd7, 8'd0, 32'd0);
    chk("R9 extint off completes", {63'd0, g_resp}, 64'd1);
    cfg_wr(6'd7, 32'h0000_0003);
    run_ev(3'd5, 8'd0, 32'd0);
    chk("R7 invalidate on exits", {60'd0, g_rsn}, 64'd5);
    guest_ie = 1'b0;
    run_ev(3'd7, 8'd0, 32'd0);
    chk("R9 extint exits with ie=0", {60'd0, g_rsn}, 64'd7);
    run_ev(3'd6, 8'd0, 32'd0);
    chk("R8 capability exits", {60'd0, g_rsn}, 64'd6);
    cfg_wr(6'd7, 32'h0000_0000);
  endtask

  task automatic t_intwin();
    cfg_wr(6'd7, 32'h0000_0004);
    run_ev(3'd2, 8'd0, 32'd0);
    chk("R10 ie=0 no window exit", {63'd0, g_resp}, 64'd1);
    @(negedge clk);
    guest_ie = 1'b1;
    ev_valid = 1'b1; ev_kind = 3'd2;
    #0.5;
    chk("R10 ready low", {63'd0, ev_ready}, 64'd0);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    chk("R10 window exit", {63'd0, exit_req}, 64'd1);
    chk("R10 reason", {60'd0, exit_reason}, 64'd8);
    chk("R10 event not taken", {63'd0, resp_valid}, 64'd0);
    guest_ie = 1'b0;
    cfg_wr(6'd7, 32'h0000_0000);
    ack();
    chk("R11 cleared by ack", {63'd0, exit_req}, 64'd0);
    chk("R10 no stray resp", {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 3'd6;
    @(posedge clk); #1;
    ev_kind = 3'd2;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R11 held", {63'd0, exit_req}, 64'd1);
      chk("R11 reason stable", {60'd0, exit_reason}, 64'd6);
      chk("R11 ready low", {63'd0, ev_ready}, 64'd0);
      chk("R11 ignored event", {63'd0, resp_valid}, 64'd0);
    end
    ev_valid = 1'b0;
    ack();
    chk("R11 released", {63'd0, exit_req}, 64'd0);
    @(posedge clk); #1;
    chk("R11 no late resp", {63'd0, resp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cr();
    t_bitmaps();
    t_tsc();
    t_ctl();
    t_intwin();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule